// File: doc/BRIEF.md
# Indirect Analog Control Register Port

This block gives a host access to a bank of thirty-two byte-wide analog control registers (mixer routing, gain and enable settings) through one 32-bit configuration word. The word carries a 5-bit index into the bank, a byte of data to store, a mode bit that picks reading or writing, and a run bit that either holds the bank cleared or lets it operate. The low byte of the word is read-only. It always shows the bank entry selected by the index field.

The host writes the whole word in one cycle with `host_we` and can read it back at any time on `host_rdata`. A controller keeps the run and mode bits as a four-state machine. The states are HELD_RD (run low, read mode), HELD_WR (run low, write mode), READ (run high, read mode) and WRITE (run high, write mode). Any host write can move the machine from any state to any other state; the next state is decoded directly from bits 28 and 24 of the written word.

The two held states clear every entry on each clock. WRITE stores the data byte into the indexed entry on each clock. READ leaves the bank alone.

To write, software first sets the index, then the data, and sets the mode bit last. To read, it clears the mode bit, sets the index, and reads the word back.

Top module: `anaport_top`

## Requirements
- R1: After `rst_n` is released, `host_rdata` reads 0x00000000 and all bank entries read zero.
- R2: The stored fields read back exactly as written: run at bit 28, mode at bit 24, index at bits [20:16] and data at bits [15:8]. Bits [31:29], [27:25] and [23:21] always read zero.
- R3: While the run bit (28) is 0, every clock clears all 32 entries. Write mode (bit 24 = 1) then changes nothing, and any entry read later returns 0x00.
- R4: With run = 1 and mode = 1, the clock edge after the word is stored writes the data byte into the indexed entry. From then on, bits [7:0] show that byte.
- R5: While write mode stays set, each new index and data value written by the host is committed on the following clock. Several entries can therefore be loaded without leaving write mode.
- R6: With run = 1 and mode = 0, no entry changes. Bits [7:0] show the entry at the current index within the same cycle, and they stay stable while the word is not rewritten.
- R7: Clearing the run bit after entries have been loaded returns every one of them to zero. This is visible once run is set again in read mode.
- R8: The value the host writes into bits [7:0] has no effect. The read field still shows the bank entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for the configuration word |
| host_wdata | input | 32 | Configuration word written by the host |
| host_rdata | output | 32 | Stored fields plus live read byte |

## Verification
Assertions check the following on every cycle:
- a write-mode clock stores the byte at the index sampled on that clock;
- a held clock leaves the read byte at zero;
- a host write is reflected in the stored fields on the next cycle;
- read mode keeps the read byte steady.

Some behaviour can only be shown by the bench scenarios, because it needs a history of writes. These scenarios cover:
- loading several entries without leaving write mode;
- clearing a bank that was loaded earlier, then reading it back after run is set again;
- confirming that write mode with run low stored nothing;
- confirming that a byte written into the read-only field never reaches the bank.

// File: rtl/anaport_pkg.sv
package anaport_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int RUN_BIT  = 28;
    localparam int MODE_BIT = 24;
    localparam int ADDR_LSB = 16;
    localparam int WDAT_LSB = 8;
    localparam int RDAT_LSB = 0;

    typedef enum logic [1:0] {
        ST_HELD_RD = 2'd0,
        ST_HELD_WR = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } port_state_e;
endpackage

// File: rtl/anaport_ctl.sv
module anaport_ctl
    import anaport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output port_state_e       state,
    output logic [ADDR_W-1:0] idx,
    output logic [DATA_W-1:0] wbyte,
    output logic              bank_we,
    output logic              bank_clr
);
    port_state_e next_state;

    always_comb begin
        next_state = state;
        if (host_we) begin
            unique case ({host_wdata[RUN_BIT], host_wdata[MODE_BIT]})
                2'b00: next_state = ST_HELD_RD;
                2'b01: next_state = ST_HELD_WR;
                2'b10: next_state = ST_READ;
                2'b11: next_state = ST_WRITE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HELD_RD;
            idx   <= '0;
            wbyte <= '0;
        end else begin
            state <= next_state;
            if (host_we) begin
                idx   <= host_wdata[ADDR_LSB +: ADDR_W];
                wbyte <= host_wdata[WDAT_LSB +: DATA_W];
            end
        end
    end

    always_comb begin
        bank_we  = 1'b0;
        bank_clr = 1'b0;
        unique case (state)
            ST_HELD_RD: bank_clr = 1'b1;
            ST_HELD_WR: bank_clr = 1'b1;
            ST_READ:    bank_we  = 1'b0;
            ST_WRITE:   bank_we  = 1'b1;
        endcase
    end

    // R7: a host word with run low puts the bank into clearing on the next cycle
    assert_clear_after_run_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_wdata[RUN_BIT]) |=> bank_clr);
endmodule

// File: rtl/anaport_bank.sv
module anaport_bank
    import anaport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R3: after a clearing clock any entry reads zero
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rdata == '0 || !$stable(addr) || $stable(addr)) && mem[addr] == '0);
    // R4: a write clock commits the byte at the index sampled on that clock
    assert_write_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/anaport_top.sv
module anaport_top
    import anaport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata
);
    localparam logic [WORD_W-1:0] FIELD_MASK =
        (WORD_W'(1) << RUN_BIT) | (WORD_W'(1) << MODE_BIT) |
        (WORD_W'((1 << ADDR_W) - 1) << ADDR_LSB) |
        (WORD_W'((1 << DATA_W) - 1) << WDAT_LSB);

    port_state_e       state;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] wbyte;
    logic [DATA_W-1:0] rbyte;
    logic              bank_we;
    logic              bank_clr;

    anaport_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .state      (state),
        .idx        (idx),
        .wbyte      (wbyte),
        .bank_we    (bank_we),
        .bank_clr   (bank_clr)
    );

    anaport_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bank_clr),
        .we    (bank_we),
        .addr  (idx),
        .wdata (wbyte),
        .rdata (rbyte)
    );

    always_comb begin
        host_rdata                        = '0;
        host_rdata[RUN_BIT]               = (state == ST_READ) || (state == ST_WRITE);
        host_rdata[MODE_BIT]              = (state == ST_HELD_WR) || (state == ST_WRITE);
        host_rdata[ADDR_LSB +: ADDR_W]    = idx;
        host_rdata[WDAT_LSB +: DATA_W]    = wbyte;
        host_rdata[RDAT_LSB +: DATA_W]    = rbyte;
    end

    // R2: a host word is reflected in the stored fields one cycle later
    assert_fields_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (host_rdata & FIELD_MASK) == ($past(host_wdata) & FIELD_MASK));
    // R6: read mode with no new host word keeps the whole word steady
    assert_read_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !host_we) |=> $stable(host_rdata));
endmodule

// File: tb/test_anaport_top.sv
module test_anaport_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    string       q_tag [$];
    logic [31:0] q_exp [$];

    logic [7:0]  model [32];
    logic [31:0] stored = '0;

    always #10 clk = ~clk;

    anaport_top i_anaport_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    function automatic logic [31:0] mk(bit run, bit mode, int a, int d, int junk);
        return (32'(run) << 28) | (32'(mode) << 24) | (32'(a & 31) << 16)
             | (32'(d & 255) << 8) | 32'(junk & 255);
    endfunction

    // effect of the currently stored word on one clock edge
    task automatic apply_edge();
        if (!stored[28]) begin
            for (int i = 0; i < 32; i++) model[i] = 8'h00;
        end else if (stored[24]) begin
            model[stored[20:16]] = stored[15:8];
        end
    endtask

    task automatic wr(logic [31:0] w);
        host_we    = 1'b1;
        host_wdata = w;
        @(posedge clk);
        apply_edge();
        stored = w;
        #1;
        host_we = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        apply_edge();
        #1;
    endtask

    task automatic expect_word(string tag);
        logic [31:0] e;
        e = (stored & 32'h111F_FF00) | 32'(model[stored[20:16]]);
        q_tag.push_back(tag);
        q_exp.push_back(e);
        wait (q_exp.size() == 0);
    endtask

    // monitor: pops expectations and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_exp.size() > 0) begin
                string t;
                logic [31:0] e;
                t = q_tag.pop_front();
                e = q_exp.pop_front();
                checks++;
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%08h expected=%08h", t, host_rdata, e);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        expect_word("R1 reset word");

        // R4: write then read back
        wr(mk(1, 1, 5, 8'hA5, 0));
        wr(mk(1, 0, 5, 0, 0));
        expect_word("R4 write visible in read mode");

        // R2: all ones word, unused bits zero; byte lands one edge later (R4)
        wr(32'hFFFF_FFFF);
        expect_word("R2 field readback before commit");
        idle();
        expect_word("R4 commit after one edge");

        // R5: stream several entries in write mode
        wr(mk(1, 1, 1, 8'h11, 0));
        wr(mk(1, 1, 2, 8'h22, 0));
        wr(mk(1, 1, 3, 8'h33, 0));
        wr(mk(1, 0, 1, 0, 0));
        expect_word("R5 entry 1");
        wr(mk(1, 0, 2, 0, 0));
        expect_word("R5 entry 2");
        wr(mk(1, 0, 3, 0, 0));
        expect_word("R5 entry 3");

        // R6: read mode with data byte set stores nothing
        wr(mk(1, 0, 4, 8'h77, 0));
        idle(); idle();
        expect_word("R6 read mode leaves entry 4");
        // R8: junk in the read field has no effect
        wr(mk(1, 0, 5, 0, 8'h5A));
        expect_word("R8 read field ignores host byte");
        idle();
        expect_word("R6 stable read");

        // R3: run low with write mode clears and ignores the write
        wr(mk(0, 1, 6, 8'h99, 0));
        expect_word("R3 held write mode word");
        idle();
        expect_word("R3 held entry zero");
        wr(mk(1, 0, 6, 0, 0));
        expect_word("R3 write while held ignored");

        // R7: earlier loaded entries are now zero
        wr(mk(1, 0, 5, 0, 0));
        expect_word("R7 entry 5 cleared");
        wr(mk(1, 0, 31, 0, 0));
        expect_word("R7 entry 31 cleared");
        wr(mk(1, 0, 1, 0, 0));
        expect_word("R7 entry 1 cleared");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule